// File: doc/BRIEF.md
# Four-Way Set-Associative Translation Buffer with Page Permissions

This block caches virtual-to-physical page translations for a 32-bit virtual address space with 4 KB pages. A lookup splits the 20-bit virtual page number into a 4-bit set selector and a 16-bit tag. It compares the tag against all four ways of the selected set in parallel. On a hit, it returns the physical address formed from the cached 20-bit physical page number and the untouched 12-bit page offset, all in the same cycle as the request.

Every cached translation carries four flags: global, supervisor-only, writable and dirty. A hit that breaks a permission raises a protection fault and reports the kind of access that caused it. The buffer sends a request to the external table walker in two cases: when no way matches, and when a write hits a translation whose dirty flag is still clear. In the second case the walker can mark the page dirty in memory and return the entry with the flag set. The walker writes translations back through a refill port.

Two flush inputs serve context switches. One keeps global translations and invalidates all others. The other wipes the whole buffer.

Top module: `tlb_assoc`

## Requirements
- R1: After reset every entry is invalid, so any lookup gives lk_walk=1, lk_hit=0 and lk_fault=0.
- R2: The set is selected by vaddr[15:12] and the tag is vaddr[31:16]. The same tag can be held in different sets at the same time, and different tags can be held in one set at the same time.
- R3: A lookup is answered combinationally in the cycle it is presented. On a hit, lk_paddr = {cached physical page number, vaddr[11:0]}.
- R4: A flush_all pulse invalidates every entry, including global ones.
- R5: A flush_nonglobal pulse invalidates every entry whose global flag is 0 and keeps every entry whose global flag is 1.
- R6: A matching entry raises lk_fault, with lk_hit=0 and lk_walk=0, in two cases: a write to an entry with writable=0, and a user access to an entry with supervisor-only=1. flt_write and flt_user then repeat lk_write and lk_user. A fault takes priority over the dirty-update request.
- R7: A write that matches an entry with dirty=0 gives lk_walk=1 and lk_hit=0. A read of that entry hits. A write to an entry with dirty=1 hits.
- R8: A refill for a translation that is not yet cached goes to the lowest-numbered invalid way of its set. If all four ways are valid, it goes to the way named by that set's round-robin pointer. The pointer starts at way 0 after reset and advances by one after each such replacement. Each set has its own pointer.
- R9: A refill whose page number is already cached overwrites that way in place. No other entry is evicted, and the round-robin pointer does not move.
- R10: A refill presented in the same cycle as either flush pulse is discarded.
- R11: When lk_valid=0, lk_hit, lk_walk and lk_fault are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request present |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_write | input | 1 | Access is a write (1) or a read (0) |
| lk_user | input | 1 | Access is from user mode (1) or supervisor mode (0) |
| lk_hit | output | 1 | Translation found and usable |
| lk_paddr | output | 32 | Physical address, valid with lk_hit |
| lk_walk | output | 1 | Request to the walker (miss or dirty update) |
| lk_fault | output | 1 | Protection violation on a matching entry |
| flt_write | output | 1 | Faulting access was a write |
| flt_user | output | 1 | Faulting access was from user mode |
| rf_valid | input | 1 | Refill write strobe |
| rf_vpn | input | 20 | Virtual page number being refilled |
| rf_ppn | input | 20 | Physical page number for the refill |
| rf_g | input | 1 | Global flag of the refill |
| rf_s | input | 1 | Supervisor-only flag of the refill |
| rf_w | input | 1 | Writable flag of the refill |
| rf_d | input | 1 | Dirty flag of the refill |
| flush_nonglobal | input | 1 | Invalidate all non-global entries |
| flush_all | input | 1 | Invalidate all entries |

## Verification
The hardest case to reach from the ports is a round-robin replacement that follows an in-place overwrite. To get there, all four ways of one set are filled with distinct tags. One of those tags is then refilled with a new page number, and two new tags are added after it. The bench can then observe which older tags now miss. That shows two things: the in-place update left the pointer at way 0, and the pointer then moved to way 1. A second set is filled afterwards to show that its pointer was unaffected by the first. Refills that land in the same cycle as a flush are driven in one clock so that the flush's precedence can be seen on the next lookup.

// File: rtl/tlb_assoc.sv
module tlb_assoc #(
  parameter int SETS  = 16,
  parameter int WAYS  = 4,
  parameter int VPN_W = 20,
  parameter int PPN_W = 20,
  parameter int OFS_W = 12
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   lk_valid,
  input  logic [VPN_W+OFS_W-1:0] lk_vaddr,
  input  logic                   lk_write,
  input  logic                   lk_user,
  output logic                   lk_hit,
  output logic [PPN_W+OFS_W-1:0] lk_paddr,
  output logic                   lk_walk,
  output logic                   lk_fault,
  output logic                   flt_write,
  output logic                   flt_user,
  input  logic                   rf_valid,
  input  logic [VPN_W-1:0]       rf_vpn,
  input  logic [PPN_W-1:0]       rf_ppn,
  input  logic                   rf_g,
  input  logic                   rf_s,
  input  logic                   rf_w,
  input  logic                   rf_d,
  input  logic                   flush_nonglobal,
  input  logic                   flush_all
);
  localparam int SET_BITS = $clog2(SETS);
  localparam int WAY_BITS = $clog2(WAYS);
  localparam int TAG_W    = VPN_W - SET_BITS;
  localparam int VA_W     = VPN_W + OFS_W;

  logic [SETS-1:0][WAYS-1:0] ent_v, ent_g, ent_s, ent_w, ent_d;
  logic [TAG_W-1:0]          ent_tag [SETS][WAYS];
  logic [PPN_W-1:0]          ent_ppn [SETS][WAYS];
  logic [WAY_BITS-1:0]       rr_ptr  [SETS];

  wire [SET_BITS-1:0] lk_set = lk_vaddr[OFS_W +: SET_BITS];
  wire [TAG_W-1:0]    lk_tag = lk_vaddr[VA_W-1 -: TAG_W];
  wire [SET_BITS-1:0] rf_set = rf_vpn[SET_BITS-1:0];
  wire [TAG_W-1:0]    rf_tag = rf_vpn[VPN_W-1 -: TAG_W];

  logic [WAYS-1:0]  lk_match;
  logic [PPN_W-1:0] sel_ppn;
  logic             sel_s, sel_w, sel_d;

  always_comb begin
    lk_match = '0;
    sel_ppn  = '0;
    sel_s    = 1'b0;
    sel_w    = 1'b0;
    sel_d    = 1'b0;
    for (int i = 0; i < WAYS; i++) begin
      if (ent_v[lk_set][i] && ent_tag[lk_set][i] == lk_tag) begin
        lk_match[i] = 1'b1;
        sel_ppn = sel_ppn | ent_ppn[lk_set][i];
        sel_s   = sel_s | ent_s[lk_set][i];
        sel_w   = sel_w | ent_w[lk_set][i];
        sel_d   = sel_d | ent_d[lk_set][i];
      end
    end
  end

  wire hit_any = |lk_match;
  wire viol    = (lk_write && !sel_w) || (lk_user && sel_s);

  assign lk_fault  = lk_valid && hit_any && viol;
  assign lk_walk   = lk_valid && !lk_fault && (!hit_any || (lk_write && !sel_d));
  assign lk_hit    = lk_valid && hit_any && !lk_fault && !lk_walk;
  assign lk_paddr  = {sel_ppn, lk_vaddr[OFS_W-1:0]};
  assign flt_write = lk_fault && lk_write;
  assign flt_user  = lk_fault && lk_user;

  logic [WAY_BITS-1:0] rf_way;
  logic                rf_rr;

  always_comb begin
    rf_way = rr_ptr[rf_set];
    rf_rr  = 1'b1;
    for (int i = 0; i < WAYS; i++) begin
      if (rf_rr && ent_v[rf_set][i] && ent_tag[rf_set][i] == rf_tag) begin
        rf_way = WAY_BITS'(i);
        rf_rr  = 1'b0;
      end
    end
    for (int i = 0; i < WAYS; i++) begin
      if (rf_rr && !ent_v[rf_set][i]) begin
        rf_way = WAY_BITS'(i);
        rf_rr  = 1'b0;
      end
    end
  end

  wire rf_take = rf_valid && !flush_all && !flush_nonglobal;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent_v <= '0;
      ent_g <= '0;
      ent_s <= '0;
      ent_w <= '0;
      ent_d <= '0;
      for (int s = 0; s < SETS; s++) rr_ptr[s] <= '0;
    end else begin
      if (rf_take) begin
        ent_v[rf_set][rf_way] <= 1'b1;
        ent_g[rf_set][rf_way] <= rf_g;
        ent_s[rf_set][rf_way] <= rf_s;
        ent_w[rf_set][rf_way] <= rf_w;
        ent_d[rf_set][rf_way] <= rf_d;
        if (rf_rr) rr_ptr[rf_set] <= rr_ptr[rf_set] + WAY_BITS'(1);
      end
      if (flush_all)            ent_v <= '0;
      else if (flush_nonglobal) ent_v <= ent_v & ent_g;
    end
  end

  always_ff @(posedge clk) begin
    if (rf_take) begin
      ent_tag[rf_set][rf_way] <= rf_tag;
      ent_ppn[rf_set][rf_way] <= rf_ppn;
    end
  end

  // R6: a fault excludes both hit and walker request
  a_r6_fault_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    lk_fault |-> (!lk_hit && !lk_walk));

  // R11: no outputs raised without a request
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |-> (!lk_hit && !lk_walk && !lk_fault));

  // R9: refill in place never leaves two ways holding one tag
  a_r9_single_match: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(lk_match) <= 1);

  // R4: full flush leaves nothing valid
  a_r4_flush_all_empty: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |=> (ent_v == '0));

  // R5: task-switch flush keeps exactly the global entries
  a_r5_keep_global: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_nonglobal && !flush_all) |=> (ent_v == $past(ent_v & ent_g)));
endmodule

// File: tb/tlb_assoc_test.sv
module tlb_assoc_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 1'b0, lk_write = 1'b0, lk_user = 1'b0;
  logic [31:0] lk_vaddr = '0;
  logic        lk_hit, lk_walk, lk_fault, flt_write, flt_user;
  logic [31:0] lk_paddr;
  logic        rf_valid = 1'b0, rf_g = 1'b0, rf_s = 1'b0, rf_w = 1'b0, rf_d = 1'b0;
  logic [19:0] rf_vpn = '0, rf_ppn = '0;
  logic        flush_nonglobal = 1'b0, flush_all = 1'b0;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tlb_assoc uut (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_write(lk_write), .lk_user(lk_user),
    .lk_hit(lk_hit), .lk_paddr(lk_paddr), .lk_walk(lk_walk), .lk_fault(lk_fault),
    .flt_write(flt_write), .flt_user(flt_user),
    .rf_valid(rf_valid), .rf_vpn(rf_vpn), .rf_ppn(rf_ppn),
    .rf_g(rf_g), .rf_s(rf_s), .rf_w(rf_w), .rf_d(rf_d),
    .flush_nonglobal(flush_nonglobal), .flush_all(flush_all)
  );

  function automatic logic [31:0] va(input logic [15:0] tag, input logic [3:0] set,
                                     input logic [11:0] ofs);
    return {tag, set, ofs};
  endfunction

  task automatic refill(input logic [15:0] tag, input logic [3:0] set, input logic [19:0] ppn,
                        input logic g, input logic s, input logic w, input logic d);
    @(negedge clk);
    rf_valid = 1'b1; rf_vpn = {tag, set}; rf_ppn = ppn;
    rf_g = g; rf_s = s; rf_w = w; rf_d = d;
    @(negedge clk);
    rf_valid = 1'b0;
  endtask

  task automatic pulse_flush(input bit all);
    @(negedge clk);
    if (all) flush_all = 1'b1; else flush_nonglobal = 1'b1;
    @(negedge clk);
    flush_all = 1'b0; flush_nonglobal = 1'b0;
  endtask

  task automatic expect_lk(input string req, input logic [31:0] addr, input logic wr,
                           input logic usr, input logic eh, input logic ew, input logic ef,
                           input logic [19:0] eppn);
    logic [31:0] ep;
    @(negedge clk);
    lk_valid = 1'b1; lk_vaddr = addr; lk_write = wr; lk_user = usr;
    #1;
    ep = {eppn, addr[11:0]};
    checks++;
    if (lk_hit !== eh || lk_walk !== ew || lk_fault !== ef || (eh && lk_paddr !== ep)) begin
      fails++;
      $display("FAIL %s addr=%h hit/walk/fault=%b%b%b paddr=%h expected %b%b%b paddr=%h",
               req, addr, lk_hit, lk_walk, lk_fault, lk_paddr, eh, ew, ef, ep);
    end
    lk_valid = 1'b0;
  endtask

  task automatic test_reset_idle();
    @(negedge clk);
    lk_valid = 1'b0; lk_vaddr = va(16'h1234, 4'd3, 12'h0);
    #1;
    checks++;
    if (lk_hit || lk_walk || lk_fault) begin
      fails++;
      $display("FAIL R11 idle outputs hit/walk/fault=%b%b%b expected 000", lk_hit, lk_walk, lk_fault);
    end
    expect_lk("R1", va(16'h1234, 4'd3, 12'h010), 1'b0, 1'b0, 0, 1, 0, '0);
    expect_lk("R1", va(16'h0000, 4'd0, 12'h000), 1'b1, 1'b1, 0, 1, 0, '0);
  endtask

  task automatic test_hit_index();
    refill(16'h1234, 4'd3, 20'hABCDE, 0, 0, 1, 1);
    expect_lk("R3", va(16'h1234, 4'd3, 12'h5A5), 1'b0, 1'b1, 1, 0, 0, 20'hABCDE);
    expect_lk("R2", va(16'h1234, 4'd4, 12'h5A5), 1'b0, 1'b0, 0, 1, 0, '0);
    expect_lk("R2", va(16'h1235, 4'd3, 12'h5A5), 1'b0, 1'b0, 0, 1, 0, '0);
    refill(16'h1234, 4'd4, 20'h11111, 0, 0, 1, 1);
    refill(16'h1235, 4'd3, 20'h22222, 0, 0, 1, 1);
    expect_lk("R2", va(16'h1234, 4'd4, 12'hFFF), 1'b0, 1'b0, 1, 0, 0, 20'h11111);
    expect_lk("R2", va(16'h1234, 4'd3, 12'h000), 1'b1, 1'b0, 1, 0, 0, 20'hABCDE);
    expect_lk("R2", va(16'h1235, 4'd3, 12'h123), 1'b0, 1'b0, 1, 0, 0, 20'h22222);
  endtask

  task automatic test_permissions();
    refill(16'h2000, 4'd5, 20'h33333, 0, 1, 0, 0);
    expect_lk("R6", va(16'h2000, 4'd5, 12'h004), 1'b0, 1'b1, 0, 0, 1, '0);
    lk_valid = 1'b1; lk_vaddr = va(16'h2000, 4'd5, 12'h004); lk_write = 1'b0; lk_user = 1'b1;
    #1;
    checks++;
    if (flt_user !== 1'b1 || flt_write !== 1'b0) begin
      fails++;
      $display("FAIL R6 fault type user/write=%b%b expected 10", flt_user, flt_write);
    end
    lk_valid = 1'b0;
    expect_lk("R6", va(16'h2000, 4'd5, 12'h008), 1'b1, 1'b0, 0, 0, 1, '0);
    lk_valid = 1'b1; lk_vaddr = va(16'h2000, 4'd5, 12'h008); lk_write = 1'b1; lk_user = 1'b0;
    #1;
    checks++;
    if (flt_user !== 1'b0 || flt_write !== 1'b1) begin
      fails++;
      $display("FAIL R6 fault type user/write=%b%b expected 01", flt_user, flt_write);
    end
    lk_valid = 1'b0;
    expect_lk("R6", va(16'h2000, 4'd5, 12'h00C), 1'b0, 1'b0, 1, 0, 0, 20'h33333);
  endtask

  task automatic test_dirty();
    refill(16'h3000, 4'd6, 20'h44444, 0, 0, 1, 0);
    expect_lk("R7", va(16'h3000, 4'd6, 12'h100), 1'b1, 1'b1, 0, 1, 0, '0);
    expect_lk("R7", va(16'h3000, 4'd6, 12'h100), 1'b0, 1'b1, 1, 0, 0, 20'h44444);
    refill(16'h3000, 4'd6, 20'h44444, 0, 0, 1, 1);
    expect_lk("R7", va(16'h3000, 4'd6, 12'h100), 1'b1, 1'b1, 1, 0, 0, 20'h44444);
  endtask

  task automatic test_replacement();
    for (int i = 0; i < 4; i++) refill(16'h00A0 + 16'(i), 4'd9, 20'h90000 + 20'(i), 0, 0, 1, 1);
    refill(16'h00A1, 4'd9, 20'h9FFFF, 0, 0, 1, 1);
    expect_lk("R9", va(16'h00A0, 4'd9, 12'h0), 1'b0, 1'b0, 1, 0, 0, 20'h90000);
    expect_lk("R9", va(16'h00A1, 4'd9, 12'h0), 1'b0, 1'b0, 1, 0, 0, 20'h9FFFF);
    expect_lk("R9", va(16'h00A3, 4'd9, 12'h0), 1'b0, 1'b0, 1, 0, 0, 20'h90003);
    refill(16'h00A4, 4'd9, 20'h90004, 0, 0, 1, 1);
    expect_lk("R8", va(16'h00A0, 4'd9, 12'h0), 1'b0, 1'b0, 0, 1, 0, '0);
    expect_lk("R8", va(16'h00A4, 4'd9, 12'h0), 1'b0, 1'b0, 1, 0, 0, 20'h90004);
    refill(16'h00A5, 4'd9, 20'h90005, 0, 0, 1, 1);
    expect_lk("R8", va(16'h00A1, 4'd9, 12'h0), 1'b0, 1'b0, 0, 1, 0, '0);
    expect_lk("R8", va(16'h00A2, 4'd9, 12'h0), 1'b0, 1'b0, 1, 0, 0, 20'h90002);
    for (int i = 0; i < 5; i++) refill(16'h00B0 + 16'(i), 4'd10, 20'hB0000 + 20'(i), 0, 0, 1, 1);
    expect_lk("R8", va(16'h00B0, 4'd10, 12'h0), 1'b0, 1'b0, 0, 1, 0, '0);
    expect_lk("R8", va(16'h00B1, 4'd10, 12'h0), 1'b0, 1'b0, 1, 0, 0, 20'hB0001);
  endtask

  task automatic test_flush();
    refill(16'h4000, 4'd1, 20'h55555, 1, 0, 1, 1);
    refill(16'h4001, 4'd1, 20'h66666, 0, 0, 1, 1);
    pulse_flush(1'b0);
    expect_lk("R5", va(16'h4000, 4'd1, 12'h0), 1'b0, 1'b0, 1, 0, 0, 20'h55555);
    expect_lk("R5", va(16'h4001, 4'd1, 12'h0), 1'b0, 1'b0, 0, 1, 0, '0);
    expect_lk("R5", va(16'h1234, 4'd3, 12'h0), 1'b0, 1'b0, 0, 1, 0, '0);
    pulse_flush(1'b1);
    expect_lk("R4", va(16'h4000, 4'd1, 12'h0), 1'b0, 1'b0, 0, 1, 0, '0);
    @(negedge clk);
    rf_valid = 1'b1; rf_vpn = {16'h5000, 4'd2}; rf_ppn = 20'h77777;
    rf_g = 1'b1; rf_s = 1'b0; rf_w = 1'b1; rf_d = 1'b1; flush_all = 1'b1;
    @(negedge clk);
    rf_valid = 1'b0; flush_all = 1'b0;
    expect_lk("R10", va(16'h5000, 4'd2, 12'h0), 1'b0, 1'b0, 0, 1, 0, '0);
    @(negedge clk);
    rf_valid = 1'b1; flush_nonglobal = 1'b1;
    @(negedge clk);
    rf_valid = 1'b0; flush_nonglobal = 1'b0;
    expect_lk("R10", va(16'h5000, 4'd2, 12'h0), 1'b0, 1'b0, 0, 1, 0, '0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    test_reset_idle();
    test_hit_index();
    test_permissions();
    test_dirty();
    test_replacement();
    test_flush();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule